// File: doc/BRIEF.md
# Cascaded Lookup-Table Logic Cell with Memory Mode

This block is a configurable logic cell. Two sixteen-entry, one-bit function tables (the F table, addressed by `f_in`, and the G table, addressed by `g_in`) each produce one intermediate bit. A third, eight-entry table combines those two bits with a third input taken from the control pins. The combined result appears on `h_out`. Four control pins feed a configurable role map, which gives the cell its third table input, a direct data bit, a clock enable and a set/reset for the cell's two flip-flops. Each flip-flop takes its data from the F result, the G result, the combined result or the direct data bit.

The same two function tables can also serve as user-writable synchronous memory. They work either as two independent 16x1 RAMs or, with the third-table input acting as the top address bit, as one 32x1 RAM. Table contents are loaded from configuration inputs with a load strobe. In memory modes they are then overwritten by user writes, taking data and write control from the mapped control roles.

Top module: `lut_cell_ram`

## Requirements
- R1: While `rst_n` is low, and after it is released, both function tables hold all zeros and `qx`, `qy` are 0.
- R2: A clock edge with `cfg_load` high copies `cfg_f_tbl` and `cfg_g_tbl` into the tables, overriding any memory write. Afterwards `f_out` equals F[`f_in`] and `g_out` equals G[`g_in`] combinationally (in 32x1 mode G is addressed by `f_in`).
- R3: Outside 32x1 mode, `h_out` equals `cfg_h_tbl` at index {third input, G result, F result}, with the third input as the MSB and the F result as the LSB.
- R4: Each role takes control pin `ctl[sel]`, where sel is its 2-bit selector. When `cfg_ec_en` is 0 the enable is held active. When `cfg_sr_en` is 0 set/reset is held inactive.
- R5: With the enable active and set/reset inactive, each flip-flop captures its selected source on the clock edge: code 0 = F result, 1 = G result, 2 = combined result, 3 = direct data.
- R6: Active set/reset forces a flip-flop on the next edge to its polarity bit (`cfg_xset`/`cfg_yset`: 1 sets, 0 clears), regardless of the enable.
- R7: With the enable and set/reset both inactive, both flip-flops hold their value.
- R8: With `cfg_mode` = 1 (two 16x1 RAMs), an edge with the enable active writes the direct data bit to F[`f_in`] and the third-input role bit to G[`g_in`].
- R9: With `cfg_mode` = 2 (32x1 RAM), the address is {third input, `f_in`}. A write with the enable active stores the direct data bit in G when the third input is 1 and in F when it is 0. `h_out` returns the addressed bit.
- R10: With `cfg_mode` = 0 or 3 (logic), the enable never changes table contents. Only `cfg_load` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | 0/3 logic, 1 two 16x1 RAMs, 2 one 32x1 RAM |
| cfg_load | input | 1 | Load both tables from configuration |
| cfg_f_tbl | input | 16 | F table load contents |
| cfg_g_tbl | input | 16 | G table load contents |
| cfg_h_tbl | input | 8 | Combining table contents |
| cfg_sel_h1 | input | 2 | Control pin used as third table input |
| cfg_sel_din | input | 2 | Control pin used as direct data |
| cfg_sel_ec | input | 2 | Control pin used as clock enable |
| cfg_sel_sr | input | 2 | Control pin used as set/reset |
| cfg_ec_en | input | 1 | 1 = enable comes from its pin, 0 = always enabled |
| cfg_sr_en | input | 1 | 1 = set/reset comes from its pin, 0 = never active |
| cfg_xsrc | input | 2 | Data source code for flip-flop X |
| cfg_ysrc | input | 2 | Data source code for flip-flop Y |
| cfg_xset | input | 1 | Set/reset polarity of X |
| cfg_yset | input | 1 | Set/reset polarity of Y |
| f_in | input | 4 | F table address |
| g_in | input | 4 | G table address |
| ctl | input | 4 | Control pins |
| f_out | output | 1 | F table result |
| g_out | output | 1 | G table result |
| h_out | output | 1 | Combined result or 32x1 read data |
| qx | output | 1 | Flip-flop X |
| qy | output | 1 | Flip-flop Y |

## Verification
The hardest situation to reach from the ports is the 32x1 memory mode. There, one routed control pin acts at once as an address bit, a write steering bit and an output multiplexer select, while another pin must act as the enable. The stimulus fixes the role map so these roles land on distinct pins. It walks all 32 addresses with the top bit driven through that pin, then reads every entry back through `h_out`. Random role maps and source codes in logic mode, with occasional table loads, cover the flip-flop priority cases.

// File: rtl/lut_cell_pkg.sv
// Shared types for the cascaded lookup-table cell.
// Assumes the memory-mode and data-source encodings below are fixed by the ports.
package lut_cell_pkg;
    typedef enum logic [1:0] {
        MODE_LOGIC   = 2'd0,
        MODE_RAM16X2 = 2'd1,
        MODE_RAM32   = 2'd2,
        MODE_RSVD    = 2'd3
    } mem_mode_e;

    typedef enum logic [1:0] {
        DSRC_F   = 2'd0,
        DSRC_G   = 2'd1,
        DSRC_H   = 2'd2,
        DSRC_DIN = 2'd3
    } dsrc_e;

    typedef struct packed {
        logic h1;
        logic din;
        logic ec;
        logic sr;
    } roles_t;
endpackage

// File: rtl/lut_cell_ctlmap.sv
// Control role map: routes control pins onto the four internal roles.
// Assumes the selectors are static configuration; purely combinational.
module lut_cell_ctlmap
    import lut_cell_pkg::*;
#(
    parameter int CTL_W = 4
) (
    input  logic [CTL_W-1:0]         ctl,
    input  logic [$clog2(CTL_W)-1:0] sel_h1,
    input  logic [$clog2(CTL_W)-1:0] sel_din,
    input  logic [$clog2(CTL_W)-1:0] sel_ec,
    input  logic [$clog2(CTL_W)-1:0] sel_sr,
    input  logic                     ec_en,
    input  logic                     sr_en,
    output roles_t                   roles
);
    // Pick each role from its pin; unused enable defaults active, unused set/reset inactive.
    always_comb begin
        roles.h1  = ctl[sel_h1];
        roles.din = ctl[sel_din];
        roles.ec  = ec_en ? ctl[sel_ec] : 1'b1;
        roles.sr  = sr_en ? ctl[sel_sr] : 1'b0;
    end
endmodule

// File: rtl/lut_cell_table.sv
// One-bit-wide function table usable as a synchronous-write RAM.
// Assumes load has priority over a user write; reads are combinational.
module lut_cell_table #(
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DEPTH-1:0]  init,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wdata,
    output logic              rdata,
    output logic [DEPTH-1:0]  bits_o
);
    logic [DEPTH-1:0] mem;

    // Storage update: clear on reset, bulk load, else single-bit write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem <= '0;
        end else if (load) begin
            mem <= init;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    // Combinational read of the addressed entry.
    assign rdata  = mem[addr];
    assign bits_o = mem;
endmodule

// File: rtl/lut_cell_ff.sv
// One cell flip-flop with source select, clock enable and set/reset.
// Assumes set/reset outranks the enable; value forced is given by set_val.
module lut_cell_ff
    import lut_cell_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src,
    input  logic       f_res,
    input  logic       g_res,
    input  logic       h_res,
    input  logic       din,
    input  logic       ec,
    input  logic       sr,
    input  logic       set_val,
    output logic       q
);
    logic d;

    // Data source multiplexer.
    always_comb begin
        unique case (dsrc_e'(src))
            DSRC_F:  d = f_res;
            DSRC_G:  d = g_res;
            DSRC_H:  d = h_res;
            default: d = din;
        endcase
    end

    // State: reset, then set/reset, then enabled capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (sr) begin
            q <= set_val;
        end else if (ec) begin
            q <= d;
        end
    end
endmodule

// File: rtl/lut_cell_ram.sv
// Logic cell: two function tables cascade into a combining table, a control
// role map, two flip-flops, and memory modes on the function tables.
// Assumes configuration inputs are held static between uses.
module lut_cell_ram
    import lut_cell_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CTL_W  = 4,
    localparam int DEPTH   = 1 << ADDR_W,
    localparam int SEL_W   = $clog2(CTL_W),
    localparam int H_DEPTH = 8,
    localparam int N_TBL   = 2,
    localparam int N_FF    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cfg_mode,
    input  logic               cfg_load,
    input  logic [DEPTH-1:0]   cfg_f_tbl,
    input  logic [DEPTH-1:0]   cfg_g_tbl,
    input  logic [H_DEPTH-1:0] cfg_h_tbl,
    input  logic [SEL_W-1:0]   cfg_sel_h1,
    input  logic [SEL_W-1:0]   cfg_sel_din,
    input  logic [SEL_W-1:0]   cfg_sel_ec,
    input  logic [SEL_W-1:0]   cfg_sel_sr,
    input  logic               cfg_ec_en,
    input  logic               cfg_sr_en,
    input  logic [1:0]         cfg_xsrc,
    input  logic [1:0]         cfg_ysrc,
    input  logic               cfg_xset,
    input  logic               cfg_yset,
    input  logic [ADDR_W-1:0]  f_in,
    input  logic [ADDR_W-1:0]  g_in,
    input  logic [CTL_W-1:0]   ctl,
    output logic               f_out,
    output logic               g_out,
    output logic               h_out,
    output logic               qx,
    output logic               qy
);
    mem_mode_e mode;
    roles_t    roles;
    logic      role_h1, role_din, role_ec, role_sr;
    logic      ram16, ram32;

    logic [N_TBL-1:0]             tbl_we, tbl_wd, tbl_rd;
    logic [N_TBL-1:0][ADDR_W-1:0] tbl_addr;
    logic [N_TBL-1:0][DEPTH-1:0]  tbl_init, tbl_bits;
    logic [2:0]                   h_idx;
    logic                         h_lut;
    logic [N_FF-1:0][1:0]         ff_src;
    logic [N_FF-1:0]              ff_set, ff_q;

    assign mode  = mem_mode_e'(cfg_mode);
    assign ram16 = (mode == MODE_RAM16X2);
    assign ram32 = (mode == MODE_RAM32);

    lut_cell_ctlmap #(.CTL_W(CTL_W)) u_map (
        .ctl     (ctl),
        .sel_h1  (cfg_sel_h1),
        .sel_din (cfg_sel_din),
        .sel_ec  (cfg_sel_ec),
        .sel_sr  (cfg_sel_sr),
        .ec_en   (cfg_ec_en),
        .sr_en   (cfg_sr_en),
        .roles   (roles)
    );

    assign role_h1  = roles.h1;
    assign role_din = roles.din;
    assign role_ec  = roles.ec;
    assign role_sr  = roles.sr;

    // Table addressing and write steering per memory mode.
    always_comb begin
        tbl_init[0] = cfg_f_tbl;
        tbl_init[1] = cfg_g_tbl;
        tbl_addr[0] = f_in;
        tbl_addr[1] = ram32 ? f_in : g_in;
        tbl_we[0]   = role_ec & (ram16 | (ram32 & ~role_h1));
        tbl_we[1]   = role_ec & (ram16 | (ram32 &  role_h1));
        tbl_wd[0]   = role_din;
        tbl_wd[1]   = ram16 ? role_h1 : role_din;
    end

    for (genvar t = 0; t < N_TBL; t++) begin : g_tbl
        lut_cell_table #(.ADDR_W(ADDR_W)) u_tbl (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (cfg_load),
            .init   (tbl_init[t]),
            .we     (tbl_we[t]),
            .addr   (tbl_addr[t]),
            .wdata  (tbl_wd[t]),
            .rdata  (tbl_rd[t]),
            .bits_o (tbl_bits[t])
        );
    end

    // Second-level combine, or 32-deep read mux in single-RAM mode.
    always_comb begin
        h_idx = {role_h1, tbl_rd[1], tbl_rd[0]};
        h_lut = cfg_h_tbl[h_idx];
        h_out = ram32 ? (role_h1 ? tbl_rd[1] : tbl_rd[0]) : h_lut;
    end

    assign f_out = tbl_rd[0];
    assign g_out = tbl_rd[1];

    // Per-flip-flop configuration vectors.
    always_comb begin
        ff_src[0] = cfg_xsrc;
        ff_src[1] = cfg_ysrc;
        ff_set[0] = cfg_xset;
        ff_set[1] = cfg_yset;
    end

    for (genvar i = 0; i < N_FF; i++) begin : g_ff
        lut_cell_ff u_ff (
            .clk     (clk),
            .rst_n   (rst_n),
            .src     (ff_src[i]),
            .f_res   (tbl_rd[0]),
            .g_res   (tbl_rd[1]),
            .h_res   (h_out),
            .din     (role_din),
            .ec      (role_ec),
            .sr      (role_sr),
            .set_val (ff_set[i]),
            .q       (ff_q[i])
        );
    end

    assign qx = ff_q[0];
    assign qy = ff_q[1];
endmodule

// File: rtl/lut_cell_ram_chk.sv
// Checker for lut_cell_ram, attached with bind below.
// Assumes roles and table images are brought out by the top's internal nets.
module lut_cell_ram_chk #(
    parameter int DEPTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic             load,
    input logic [1:0]       xsrc,
    input logic             xset,
    input logic             yset,
    input logic             sr,
    input logic             ec,
    input logic             din,
    input logic             h1,
    input logic [DEPTH-1:0] f_bits,
    input logic [DEPTH-1:0] g_bits,
    input logic             qx,
    input logic             qy
);
    // R6
    sr_x_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr && xset) |=> qx);
    // R6
    sr_y_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr && !yset) |=> !qy);
    // R7
    ff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sr && !ec) |=> ($stable(qx) && $stable(qy)));
    // R5
    din_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sr && ec && xsrc == 2'd3) |=> (qx == $past(din)));
    // R10
    logic_tbl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'd0 || mode == 2'd3) && !load) |=> ($stable(f_bits) && $stable(g_bits)));
    // R9
    ram32_low_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && !load && ec && !h1) |=> $stable(g_bits));
endmodule

bind lut_cell_ram lut_cell_ram_chk #(.DEPTH(DEPTH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (cfg_mode),
    .load   (cfg_load),
    .xsrc   (cfg_xsrc),
    .xset   (cfg_xset),
    .yset   (cfg_yset),
    .sr     (role_sr),
    .ec     (role_ec),
    .din    (role_din),
    .h1     (role_h1),
    .f_bits (tbl_bits[0]),
    .g_bits (tbl_bits[1]),
    .qx     (qx),
    .qy     (qy)
);

// File: tb/lut_cell_ram_tb.sv
// Self-checking bench: random logic-mode configurations plus directed memory sequences.
module lut_cell_ram_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cfg_mode;
    logic        cfg_load;
    logic [15:0] cfg_f_tbl, cfg_g_tbl;
    logic [7:0]  cfg_h_tbl;
    logic [1:0]  cfg_sel_h1, cfg_sel_din, cfg_sel_ec, cfg_sel_sr;
    logic        cfg_ec_en, cfg_sr_en;
    logic [1:0]  cfg_xsrc, cfg_ysrc;
    logic        cfg_xset, cfg_yset;
    logic [3:0]  f_in, g_in, ctl;
    logic        f_out, g_out, h_out, qx, qy;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state
    logic [15:0] fm, gm;
    logic        qxm, qym;

    always #4 clk = ~clk;

    lut_cell_ram u_dut (.*);

    function automatic logic r_h1();  return ctl[cfg_sel_h1]; endfunction
    function automatic logic r_din(); return ctl[cfg_sel_din]; endfunction
    function automatic logic r_ec();  return cfg_ec_en ? ctl[cfg_sel_ec] : 1'b1; endfunction
    function automatic logic r_sr();  return cfg_sr_en ? ctl[cfg_sel_sr] : 1'b0; endfunction
    function automatic logic e_f();   return fm[f_in]; endfunction
    function automatic logic e_g();   return (cfg_mode == 2'd2) ? gm[f_in] : gm[g_in]; endfunction
    function automatic logic e_h();
        if (cfg_mode == 2'd2) return r_h1() ? gm[f_in] : fm[f_in];
        return cfg_h_tbl[{r_h1(), e_g(), e_f()}];
    endfunction
    function automatic logic e_d(logic [1:0] s);
        case (s)
            2'd0: return e_f();
            2'd1: return e_g();
            2'd2: return e_h();
            default: return r_din();
        endcase
    endfunction

    task automatic chk(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(input string req);
        chk(f_out, e_f(), {req, " f_out"});
        chk(g_out, e_g(), {req, " g_out"});
        chk(h_out, e_h(), {req, " h_out"});
        chk(qx, qxm, {req, " qx"});
        chk(qy, qym, {req, " qy"});
    endtask

    // Advance one edge: compute model next state from pre-edge inputs.
    task automatic tick();
        logic [15:0] nf = fm, ng = gm;
        logic nx = qxm, ny = qym;
        if (cfg_load) begin
            nf = cfg_f_tbl; ng = cfg_g_tbl;
        end else if (cfg_mode == 2'd1 && r_ec()) begin
            nf[f_in] = r_din(); ng[g_in] = r_h1();
        end else if (cfg_mode == 2'd2 && r_ec()) begin
            if (r_h1()) ng[f_in] = r_din(); else nf[f_in] = r_din();
        end
        if (r_sr()) begin nx = cfg_xset; ny = cfg_yset; end
        else if (r_ec()) begin nx = e_d(cfg_xsrc); ny = e_d(cfg_ysrc); end
        @(posedge clk);
        fm = nf; gm = ng; qxm = nx; qym = ny;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        rst_n = 0; cfg_mode = 0; cfg_load = 0; cfg_f_tbl = '1; cfg_g_tbl = '1;
        cfg_h_tbl = 8'hA5; cfg_sel_h1 = 0; cfg_sel_din = 1; cfg_sel_ec = 2; cfg_sel_sr = 3;
        cfg_ec_en = 0; cfg_sr_en = 0; cfg_xsrc = 3; cfg_ysrc = 3; cfg_xset = 1; cfg_yset = 1;
        f_in = 4'd3; g_in = 4'd9; ctl = 4'hF;
        fm = '0; gm = '0; qxm = 0; qym = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset clears tables and flip-flops
        chk(qx, 1'b0, "R1 qx");
        chk(qy, 1'b0, "R1 qy");
        chk(f_out, 1'b0, "R1 f_out");
        chk(g_out, 1'b0, "R1 g_out");
        rst_n = 1;
        ctl = 4'h0;
        #1 check_all("R1 after release");
        tick();

        // Random logic-mode configurations: R2 R3 R4 R5 R6 R7, with table loads
        for (int it = 0; it < 300; it++) begin
            cfg_mode = ($urandom_range(0, 1) == 0) ? 2'd0 : 2'd3;
            cfg_load = (it % 12 == 0);
            cfg_f_tbl = 16'($urandom); cfg_g_tbl = 16'($urandom);
            cfg_h_tbl = 8'($urandom);
            cfg_sel_h1 = 2'($urandom); cfg_sel_din = 2'($urandom);
            cfg_sel_ec = 2'($urandom); cfg_sel_sr = 2'($urandom);
            cfg_ec_en = 1'($urandom); cfg_sr_en = ($urandom_range(0, 3) == 0);
            cfg_xsrc = 2'($urandom); cfg_ysrc = 2'($urandom);
            cfg_xset = 1'($urandom); cfg_yset = 1'($urandom);
            f_in = 4'($urandom); g_in = 4'($urandom); ctl = 4'($urandom);
            #1 check_all("R2 R3 R4 R5 R6 R7 random");
            tick();
        end
        cfg_load = 0;
        #1 check_all("R2 after last load");

        // R10: logic mode with enable and data active leaves tables untouched
        cfg_mode = 2'd0; cfg_ec_en = 0; cfg_sr_en = 0; cfg_sel_din = 0; cfg_sel_h1 = 1;
        for (int a = 0; a < 16; a++) begin
            f_in = 4'(a); g_in = 4'(a); ctl = ~fm[a] ? 4'hF : 4'h0;
            tick();
        end
        for (int a = 0; a < 16; a++) begin
            f_in = 4'(a); g_in = 4'(a);
            #1 chk(f_out, fm[a], "R10 F unchanged");
            chk(g_out, gm[a], "R10 G unchanged");
            #1;
        end

        // R8: two 16x1 RAMs; din on pin0, second data on pin1, enable on pin2
        cfg_mode = 2'd1; cfg_sel_din = 0; cfg_sel_h1 = 1; cfg_sel_ec = 2;
        cfg_ec_en = 1; cfg_sr_en = 0;
        for (int a = 0; a < 16; a++) begin
            f_in = 4'(a); g_in = 4'(15 - a);
            ctl = {1'b0, 1'b1, 1'($urandom), 1'($urandom)};
            tick();
        end
        ctl = 4'h0;
        for (int a = 0; a < 16; a++) begin
            f_in = 4'(a); g_in = 4'(a);
            #1 check_all("R8 readback");
            tick();
        end

        // R9: one 32x1 RAM; top address bit via pin1
        cfg_mode = 2'd2;
        for (int a = 0; a < 32; a++) begin
            f_in = 4'(a); ctl = {1'b0, 1'b1, 1'(a >> 4), 1'($urandom)};
            tick();
        end
        for (int a = 0; a < 32; a++) begin
            f_in = 4'(a); ctl = {2'b00, 1'(a >> 4), 1'b0};
            #1 chk(h_out, (a >= 16) ? gm[a % 16] : fm[a % 16], "R9 readback");
            check_all("R9 model");
            tick();
        end

        // R6 directed: set/reset outranks enable, polarity per flip-flop
        cfg_mode = 2'd0; cfg_sr_en = 1; cfg_sel_sr = 3; cfg_ec_en = 1; cfg_sel_ec = 2;
        cfg_xsrc = 2'd3; cfg_ysrc = 2'd3; cfg_sel_din = 0; cfg_xset = 1; cfg_yset = 0;
        ctl = 4'b1100;
        tick();
        #1 chk(qx, 1'b1, "R6 x set");
        chk(qy, 1'b0, "R6 y cleared");
        // R4 directed: unused enable is always active
        cfg_sr_en = 0; cfg_ec_en = 0; ctl = 4'b0001;
        tick();
        #1 chk(qx, 1'b1, "R4 forced enable x");
        chk(qy, 1'b1, "R4 forced enable y");

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule